// File: doc/BRIEF.md
# Dual-Clock FIFO with Status Flags

This block moves data words from a producer running on one clock to a consumer running on an unrelated clock. The producer pushes a word with `wr_en`; the consumer pulls with `rd_en`. Each side keeps its own binary pointer, one bit wider than the storage address. The pointer is Gray-coded into a register and crosses to the other side through a two-stage synchronizer. Each side therefore judges the FIFO level from a delayed, conservative view of the opposite pointer. Storage is a register array written on the write clock and read combinationally by the read side.

A static parameter picks one of two read styles. In standard mode `rd_data` changes only on an edge that accepts a read, and it then carries the word just removed. In fall-through mode the head word is already on `rd_data` while the FIFO is not empty, and an accepted read moves the output on to the next word. Empty, almost-empty, full and almost-full flags are registered in their own domains. Two one-cycle pulses report misuse: a read attempted while empty, and a write attempted while full. Both thresholds are parameters.

Top module: `afifo_dc`

## Requirements
- R1: While `rst_n` is low, `empty` and `almost_empty` are 1, and `full`, `almost_full`, `rd_err`, `wr_ovf` and `rd_data` are 0.
- R2: Accepted words leave the FIFO in the order they were accepted, with none lost or repeated.
- R3: In standard mode (`RD_MODE` = RD_STANDARD), a read accepted on a `rd_clk` edge places the head word on `rd_data` at that edge. On every other edge `rd_data` keeps its value.
- R4: In fall-through mode (`RD_MODE` = RD_FALLTHROUGH), `rd_data` shows the head word from the edge on which `empty` falls. An accepted read replaces it with the next word at that edge. While `empty` is high, `rd_data` holds.
- R5: `empty` rises on the same `rd_clk` edge that accepts the read of the last word visible to the read side.
- R6: A word written on a `wr_clk` edge first clears `empty` on the third `rd_clk` edge after that write edge.
- R7: An `rd_en` sampled high while `empty` is high is refused. `rd_err` is 1 for the following cycle and the read pointer does not move. In standard mode `rd_data` is also unchanged.
- R8: On each `rd_clk` edge, `almost_empty` is set to whether the occupancy seen before that edge is at most `AE_LEVEL`. A read that lowers the occupancy therefore shows in the flag one read clock later.
- R9: `full` rises on the write edge that brings the write-side occupancy to 2^`ADDR_W`. After a read, it falls no earlier than the third `wr_clk` edge following the read edge.
- R10: On each `wr_clk` edge, `almost_full` is set to whether the write-side occupancy after that edge's write is at least `AF_LEVEL`.
- R11: A `wr_en` sampled high while `full` is high is ignored. `wr_ovf` is 1 for the following cycle, and the stored contents are untouched.
- R12: If a word is written into an empty FIFO and `rd_en` is held high immediately afterwards, the first reads are refused with `rd_err`. `empty` stays high until the word has crossed into the read domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| wr_en | input | 1 | Push request |
| wr_data | input | DATA_W | Word to push |
| rd_en | input | 1 | Pull request |
| rd_data | output | DATA_W | Registered output word |
| empty | output | 1 | No word visible to the read side |
| almost_empty | output | 1 | Read-side occupancy at or below AE_LEVEL |
| full | output | 1 | Write-side occupancy equals the depth |
| almost_full | output | 1 | Write-side occupancy at or above AF_LEVEL |
| rd_err | output | 1 | Pulse: a read was refused because the FIFO was empty |
| wr_ovf | output | 1 | Pulse: a write was refused because the FIFO was full |

## Verification
The embedded properties assume that the two clocks never share an edge. They also assume that `rst_n` changes well away from both clock edges, so that each Gray pointer settles before it is sampled and no two domains leave reset on different pointer views. The bench keeps to these assumptions in three ways. It offsets the two clock phases so that their edges stay at least 3 ns apart. It drives every input 1 ns after its own clock edge. It releases reset at an instant where neither clock rises. Under these conditions the pointer crossings have a fixed latency, and the behavioural model can predict every flag edge exactly.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

   // Read-side presentation style, fixed at elaboration.
   typedef enum logic {
      RD_STANDARD    = 1'b0,
      RD_FALLTHROUGH = 1'b1
   } rd_mode_e;

endpackage

// File: rtl/afifo_sync.sv
module afifo_sync #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] stage1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage1 <= '0;
         q      <= '0;
      end else begin
         stage1 <= d;
         q      <= stage1;
      end
   end

endmodule

// File: rtl/afifo_wr_side.sv
module afifo_wr_side #(
   parameter int ADDR_W   = 3,
   parameter int AF_LEVEL = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W:0]   rgray_s,
   output logic              wr_accept,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [ADDR_W:0]   wgray,
   output logic              full,
   output logic              afull,
   output logic              wr_ovf
);

   localparam int PW    = ADDR_W + 1;
   localparam int DEPTH = 1 << ADDR_W;

   logic [PW-1:0] wptr, wptr_n, wgray_n, rsync_bin, level_n;
   logic [PW-1:0] full_pattern;
   logic          full_n;

   always_comb begin
      for (int i = 0; i < PW; i++) begin
         rsync_bin[i] = ^(rgray_s >> i);
      end
   end

   assign wr_accept    = wr_en & ~full;
   assign wptr_n       = wptr + PW'(wr_accept);
   assign wgray_n      = wptr_n ^ (wptr_n >> 1);
   // Full in Gray terms: top two bits inverted, the rest equal.
   assign full_pattern = {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]};
   assign full_n       = (wgray_n == full_pattern);
   assign level_n      = wptr_n - rsync_bin;
   assign wr_addr      = wptr[ADDR_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr   <= '0;
         wgray  <= '0;
         full   <= 1'b0;
         afull  <= 1'b0;
         wr_ovf <= 1'b0;
      end else begin
         wptr   <= wptr_n;
         wgray  <= wgray_n;
         full   <= full_n;
         afull  <= (level_n >= PW'(AF_LEVEL));
         wr_ovf <= wr_en & full;
      end
   end

   // R10
   full_implies_afull_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> afull);

   // R11
   ovf_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ovf |-> wptr == $past(wptr));

   // R9
   wr_level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wptr - rsync_bin) <= PW'(DEPTH));

endmodule

// File: rtl/afifo_rd_side.sv
module afifo_rd_side
   import afifo_pkg::*;
#(
   parameter int       ADDR_W   = 3,
   parameter int       DATA_W   = 8,
   parameter int       AE_LEVEL = 2,
   parameter rd_mode_e RD_MODE  = RD_STANDARD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [ADDR_W:0]   wgray_s,
   input  logic [DATA_W-1:0] mem_q,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [ADDR_W:0]   rgray,
   output logic              empty,
   output logic              aempty,
   output logic              rd_err,
   output logic [DATA_W-1:0] rd_data
);

   localparam int PW    = ADDR_W + 1;
   localparam int DEPTH = 1 << ADDR_W;

   logic [PW-1:0] rptr, rptr_n, rgray_n, wsync_bin, level;
   logic          accept, empty_n, load;

   always_comb begin
      for (int i = 0; i < PW; i++) begin
         wsync_bin[i] = ^(wgray_s >> i);
      end
   end

   assign accept  = rd_en & ~empty;
   assign rptr_n  = rptr + PW'(accept);
   assign rgray_n = rptr_n ^ (rptr_n >> 1);
   assign empty_n = (rgray_n == wgray_s);
   assign level   = wsync_bin - rptr;

   generate
      if (RD_MODE == RD_FALLTHROUGH) begin : g_fwft
         // Pre-load the next head so it is visible before any strobe.
         assign rd_addr = rptr_n[ADDR_W-1:0];
         assign load    = ~empty_n;
      end else begin : g_std
         assign rd_addr = rptr[ADDR_W-1:0];
         assign load    = accept;

         // R7
         std_err_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_err |-> rd_data == $past(rd_data));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr    <= '0;
         rgray   <= '0;
         empty   <= 1'b1;
         aempty  <= 1'b1;
         rd_err  <= 1'b0;
         rd_data <= '0;
      end else begin
         rptr   <= rptr_n;
         rgray  <= rgray_n;
         empty  <= empty_n;
         aempty <= (level <= PW'(AE_LEVEL));
         rd_err <= rd_en & empty;
         if (load) begin
            rd_data <= mem_q;
         end
      end
   end

   // R8
   empty_implies_aempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> aempty);

   // R7
   rderr_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_err |-> rptr == $past(rptr));

   // R2
   rd_level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      level <= PW'(DEPTH));

endmodule

// File: rtl/afifo_dc.sv
module afifo_dc
   import afifo_pkg::*;
#(
   parameter int       DATA_W   = 8,
   parameter int       ADDR_W   = 3,
   parameter int       AE_LEVEL = 2,
   parameter int       AF_LEVEL = 6,
   parameter rd_mode_e RD_MODE  = RD_STANDARD
) (
   input  logic              wr_clk,
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              empty,
   output logic              almost_empty,
   output logic              full,
   output logic              almost_full,
   output logic              rd_err,
   output logic              wr_ovf
);

   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("afifo_dc: ADDR_W must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("afifo_dc: DATA_W must be positive");
      end
      if (AE_LEVEL < 1 || AE_LEVEL >= DEPTH) begin : g_bad_ae
         $error("afifo_dc: AE_LEVEL must lie in 1..DEPTH-1");
      end
      if (AF_LEVEL < 1 || AF_LEVEL > DEPTH) begin : g_bad_af
         $error("afifo_dc: AF_LEVEL must lie in 1..DEPTH");
      end
   endgenerate

   logic [DATA_W-1:0] mem [DEPTH];
   logic [ADDR_W:0]   wgray, rgray, wgray_s, rgray_s;
   logic [ADDR_W-1:0] wr_addr, rd_addr;
   logic              wr_accept;
   logic [DATA_W-1:0] mem_q;

   always_ff @(posedge wr_clk) begin
      if (wr_accept) begin
         mem[wr_addr] <= wr_data;
      end
   end

   assign mem_q = mem[rd_addr];

   afifo_sync #(.WIDTH(ADDR_W + 1)) u_w2r (
      .clk   (rd_clk),
      .rst_n (rst_n),
      .d     (wgray),
      .q     (wgray_s)
   );

   afifo_sync #(.WIDTH(ADDR_W + 1)) u_r2w (
      .clk   (wr_clk),
      .rst_n (rst_n),
      .d     (rgray),
      .q     (rgray_s)
   );

   afifo_wr_side #(
      .ADDR_W   (ADDR_W),
      .AF_LEVEL (AF_LEVEL)
   ) u_wr (
      .clk       (wr_clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .rgray_s   (rgray_s),
      .wr_accept (wr_accept),
      .wr_addr   (wr_addr),
      .wgray     (wgray),
      .full      (full),
      .afull     (almost_full),
      .wr_ovf    (wr_ovf)
   );

   afifo_rd_side #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .AE_LEVEL (AE_LEVEL),
      .RD_MODE  (RD_MODE)
   ) u_rd (
      .clk     (rd_clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .wgray_s (wgray_s),
      .mem_q   (mem_q),
      .rd_addr (rd_addr),
      .rgray   (rgray),
      .empty   (empty),
      .aempty  (almost_empty),
      .rd_err  (rd_err),
      .rd_data (rd_data)
   );

endmodule

// File: tb/afifo_dc_tb.sv
module afifo_dc_tb;
   import afifo_pkg::*;

   localparam int DW    = 8;
   localparam int AW    = 3;
   localparam int DEPTH = 1 << AW;
   localparam int AE    = 2;
   localparam int AF    = 6;

   logic          wclk = 1'b0;
   logic          rclk = 1'b0;
   logic          rst_n = 1'b1;
   logic          wren = 1'b0;
   logic          rden = 1'b0;
   logic [DW-1:0] wdata = '0;

   logic [DW-1:0] rd_s, rd_f;
   logic emp_s, ae_s, full_s, af_s, rerr_s, ovf_s;
   logic emp_f, ae_f, full_f, af_f, rerr_f, ovf_f;

   // 50 MHz write clock, rises at 10 + 20k ns
   always #10 wclk = ~wclk;
   // read clock rises at 3 + 30k ns: never within 3 ns of a write edge
   initial begin
      #3;
      forever begin
         rclk = 1'b1; #15;
         rclk = 1'b0; #15;
      end
   end

   afifo_dc #(.DATA_W(DW), .ADDR_W(AW), .AE_LEVEL(AE), .AF_LEVEL(AF),
              .RD_MODE(RD_STANDARD)) u_dut (
      .wr_clk(wclk), .rd_clk(rclk), .rst_n(rst_n), .wr_en(wren), .wr_data(wdata),
      .rd_en(rden), .rd_data(rd_s), .empty(emp_s), .almost_empty(ae_s),
      .full(full_s), .almost_full(af_s), .rd_err(rerr_s), .wr_ovf(ovf_s));

   afifo_dc #(.DATA_W(DW), .ADDR_W(AW), .AE_LEVEL(AE), .AF_LEVEL(AF),
              .RD_MODE(RD_FALLTHROUGH)) u_dut_fw (
      .wr_clk(wclk), .rd_clk(rclk), .rst_n(rst_n), .wr_en(wren), .wr_data(wdata),
      .rd_en(rden), .rd_data(rd_f), .empty(emp_f), .almost_empty(ae_f),
      .full(full_f), .almost_full(af_f), .rd_err(rerr_f), .wr_ovf(ovf_f));

   int checks = 0;
   int errors = 0;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
      end
   endtask

   // ---------------- behavioural reference ----------------
   int wcnt = 0, rcnt = 0;
   int w_rs1 = 0, w_rs2 = 0, r_ws1 = 0, r_ws2 = 0;
   bit full_m = 0, af_m = 0, ovf_m = 0;
   bit empty_m = 1, ae_m = 1, rerr_m = 0;
   int dout_s = 0, dout_f = 0;
   int log_m[$];
   bit wacc, racc;

   always @(posedge wclk) begin
      if (rst_n) begin
         wacc  = wren && !full_m;
         ovf_m = wren && full_m;
         if (wacc) begin
            log_m.push_back(int'(wdata));
            wcnt++;
         end
         full_m = (wcnt - w_rs2) == DEPTH;
         af_m   = (wcnt - w_rs2) >= AF;
         w_rs2  = w_rs1;
         w_rs1  = rcnt;
      end
   end

   always @(posedge rclk) begin
      if (rst_n) begin
         racc   = rden && !empty_m;
         rerr_m = rden && empty_m;
         ae_m   = (r_ws2 - rcnt) <= AE;
         if (racc) begin
            dout_s = log_m[rcnt];
            rcnt++;
         end
         empty_m = (rcnt == r_ws2);
         if (!empty_m) dout_f = log_m[rcnt];
         r_ws2 = r_ws1;
         r_ws1 = wcnt;
      end
   end

   // ---------------- per-cycle comparison ----------------
   always @(posedge wclk) begin
      if (rst_n) begin
         #3;
         chk("R9 full std", int'(full_s), int'(full_m));
         chk("R9 full fwft", int'(full_f), int'(full_m));
         chk("R10 almost_full std", int'(af_s), int'(af_m));
         chk("R10 almost_full fwft", int'(af_f), int'(af_m));
         chk("R11 wr_ovf std", int'(ovf_s), int'(ovf_m));
         chk("R11 wr_ovf fwft", int'(ovf_f), int'(ovf_m));
      end
   end

   always @(posedge rclk) begin
      if (rst_n) begin
         #3;
         chk("R5 R6 empty std", int'(emp_s), int'(empty_m));
         chk("R5 R6 empty fwft", int'(emp_f), int'(empty_m));
         chk("R8 almost_empty std", int'(ae_s), int'(ae_m));
         chk("R8 almost_empty fwft", int'(ae_f), int'(ae_m));
         chk("R7 R12 rd_err std", int'(rerr_s), int'(rerr_m));
         chk("R7 R12 rd_err fwft", int'(rerr_f), int'(rerr_m));
         chk("R2 R3 rd_data std", int'(rd_s), dout_s);
         chk("R2 R4 rd_data fwft", int'(rd_f), dout_f);
      end
   end

   // ---------------- watchdog ----------------
   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      #2 rst_n = 1'b0;
      #58;
      // R1 reset state on both variants
      chk("R1 empty", int'(emp_s & emp_f), 1);
      chk("R1 almost_empty", int'(ae_s & ae_f), 1);
      chk("R1 full", int'(full_s | full_f), 0);
      chk("R1 almost_full", int'(af_s | af_f), 0);
      chk("R1 rd_err", int'(rerr_s | rerr_f), 0);
      chk("R1 wr_ovf", int'(ovf_s | ovf_f), 0);
      chk("R1 rd_data", int'(rd_s | rd_f), 0);
      #41 rst_n = 1'b1;

      fork
         begin : wr_proc
            repeat (10) @(posedge wclk);
            // R12: single write while the reader is already strobing
            @(posedge wclk); #1 wren = 1'b1; wdata = 8'hA5;
            @(posedge wclk); #1 wren = 1'b0;
            repeat (30) @(posedge wclk);
            // R9 R10 R11: fill past the depth with no reads
            for (int i = 0; i < 12; i++) begin
               @(posedge wclk); #1 wren = 1'b1; wdata = 8'(8'h10 + i);
            end
            @(posedge wclk); #1 wren = 1'b0;
            repeat (80) @(posedge wclk);
            // mixed traffic: write-heavy, then read-heavy
            for (int i = 0; i < 3000; i++) begin
               @(posedge wclk); #1;
               wren  = (($urandom % 100) < ((i < 1500) ? 70 : 35));
               wdata = 8'($urandom);
            end
            @(posedge wclk); #1 wren = 1'b0;
         end
         begin : rd_proc
            // R7 R12: strobe reads from an empty FIFO and through the single write
            for (int i = 0; i < 25; i++) begin
               @(posedge rclk); #1 rden = 1'b1;
            end
            @(posedge rclk); #1 rden = 1'b0;
            repeat (20) @(posedge rclk);
            // R5 R8: drain the full FIFO and keep strobing past empty
            for (int i = 0; i < 16; i++) begin
               @(posedge rclk); #1 rden = 1'b1;
            end
            @(posedge rclk); #1 rden = 1'b0;
            repeat (30) @(posedge rclk);
            for (int i = 0; i < 2000; i++) begin
               @(posedge rclk); #1;
               rden = (($urandom % 100) < ((i < 1000) ? 35 : 80));
            end
            @(posedge rclk); #1 rden = 1'b1;
            repeat (40) @(posedge rclk);
            #1 rden = 1'b0;
         end
      join

      repeat (20) @(posedge rclk);
      #5;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule